// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Bank

This block holds a small bank of event counters (one to four). Each counter has a 32-bit control word next to it. The control word chooses one of 64 event lines, the privilege modes in which counting is allowed, and whether the counter may raise an interrupt. Software reaches both registers of every counter through a plain register port. That port has an index, a control/counter select, a write strobe and a read strobe.

The block counts an event only in the modes that the control word permits. Software starts a sampling period by loading a counter with 0x80000000 minus the period. The counter requests an interrupt once its top bit is set, provided its interrupt enable is on. The requests of all counters are ORed onto a single line. The top bit of each control word is a fixed, read-only chain flag. Software reads control words one after another until this flag reads 0, and the number read gives the counter count.

Top module: `perf_ctr_unit`

## Requirements
- R1: After reset, every control word reads only its chain flag, every counter reads 0, and irq_o is low.
- R2: The control word fields are as follows.
  - Bit 0 permits counting while exl_i is high.
  - Bit 1 permits counting in kernel mode, bit 2 in supervisor mode and bit 3 in user mode.
  - Bit 4 is the interrupt enable.
  - Bits 10:5 are the event selector.
  - Bits 30:11 always read 0, and writes to them are ignored.
- R3: Control bit 31 reads 1 on every counter index below NUM_CTR-1 and reads 0 on the last one. Writes never change it.
- R4: A counter adds exactly one on each clock in which its permission holds and its selected event is high. The permission is set as follows.
  - While exl_i is high, bit 0 alone decides it.
  - Otherwise priv_mode_i selects the bit: 0 = kernel (bit 1), 1 = supervisor (bit 2), 2 = user (bit 3).
  - priv_mode_i = 3 never counts.
- R5: A counter responds only to evt_i[sel], where sel is its control bits 10:5. All other event lines have no effect on it.
- R6: irq_o is high exactly when some counter has control bit 4 = 1 and counter bit 31 = 1. It follows the registers in the same cycle they change.
- R7: A counter preloaded with 0x80000000 - N, with its interrupt enabled, raises irq_o after exactly N counted events and not before.
- R8: A software write to a counter in the same cycle as a counted event stores the written value and drops the increment.
- R9: Counters wrap modulo 2^32: 0xFFFFFFFF plus one event gives 0.
- R10: A read strobe returns the selected register on rd_data_o one cycle later. An index at or above NUM_CTR reads 0, and writes to such an index change nothing.
- R11: A counter whose control word is written to 0 does not count, whatever the events and modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 64 | Event lines, one pulse per cycle counts once |
| priv_mode_i | input | 2 | 0 kernel, 1 supervisor, 2 user, 3 none |
| exl_i | input | 1 | Exception-level flag |
| idx_i | input | IDX_W | Counter index for register access |
| sel_ctl_i | input | 1 | 1 selects the control word, 0 the counter |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | OR of all counter interrupt requests |

## Verification
Writes and event increments land on the clock edge that samples them. irq_o is combinational from the registers, so it changes on that same edge. rd_data_o appears one edge after the read strobe. The bench drives every input on the falling edge and reads each result on the next falling edge, half a cycle after the edge that is due to produce it. In the permission sweep, every event pulse lasts exactly one edge, so the expected counter value is 0 or 1. The preload test checks irq_o after each single event, so an off-by-one shows up on the exact edge where it occurs.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 6;
  localparam int EVT_N  = 1 << SEL_W;
  localparam int B_EXL  = 0;
  localparam int B_KERN = 1;
  localparam int B_SUP  = 2;
  localparam int B_USER = 3;
  localparam int B_IE   = 4;
  localparam int SEL_LO = 5;
  localparam int SEL_HI = SEL_LO + SEL_W - 1;
  localparam int CTL_W  = SEL_HI + 1;

  typedef enum logic [1:0] {
    PM_KERNEL = 2'd0,
    PM_SUPER  = 2'd1,
    PM_USER   = 2'd2,
    PM_NONE   = 2'd3
  } priv_mode_e;
endpackage

// File: rtl/perf_mode_gate.sv
module perf_mode_gate
  import perf_pkg::*;
(
  input  logic [3:0]  mask_i,
  input  priv_mode_e  priv_mode_i,
  input  logic        exl_i,
  output logic        en_o
);
  logic mode_ok;

  always_comb begin
    unique case (priv_mode_i)
      PM_KERNEL: mode_ok = mask_i[B_KERN];
      PM_SUPER:  mode_ok = mask_i[B_SUP];
      PM_USER:   mode_ok = mask_i[B_USER];
      default:   mode_ok = 1'b0;
    endcase
  end

  // exception level overrides the mode qualifier
  assign en_o = exl_i ? mask_i[B_EXL] : mode_ok;
endmodule

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice
  import perf_pkg::*;
#(
  parameter bit HAS_NEXT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              cnt_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [EVT_N-1:0]  evt_i,
  input  priv_mode_e        priv_mode_i,
  input  logic              exl_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              req_o
);
  localparam int PAD_W = DATA_W - 1 - CTL_W;

  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] cnt_q;
  logic              gate_en;
  logic              evt_sel;
  logic              inc;

  perf_mode_gate u_gate (
    .mask_i      (ctl_q[B_USER:B_EXL]),
    .priv_mode_i (priv_mode_i),
    .exl_i       (exl_i),
    .en_o        (gate_en)
  );

  assign evt_sel = evt_i[ctl_q[SEL_HI:SEL_LO]];
  assign inc     = gate_en & evt_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= wdata_i[CTL_W-1:0];
  end

  // software write wins over increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= wdata_i;
    else if (inc)      cnt_q <= cnt_q + 1'b1;
  end

  assign ctl_o = {HAS_NEXT, {PAD_W{1'b0}}, ctl_q};
  assign cnt_o = cnt_q;
  assign req_o = ctl_q[B_IE] & cnt_q[DATA_W-1];

  assert_wr_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_q == $past(wdata_i));

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && !cnt_we_i) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc && !cnt_we_i) |=> $stable(cnt_q));

  assert_no_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_mode_i == PM_NONE && !exl_i) |-> !gate_en);
endmodule

// File: rtl/perf_ctr_unit.sv
module perf_ctr_unit
  import perf_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int IDX_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [63:0]       evt_i,
  input  logic [1:0]        priv_mode_i,
  input  logic              exl_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              sel_ctl_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);
  localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_CTR);

  logic [DATA_W-1:0] ctl_rd [NUM_CTR];
  logic [DATA_W-1:0] cnt_rd [NUM_CTR];
  logic [NUM_CTR-1:0] req;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q;
  priv_mode_e        pm;

  assign pm = priv_mode_e'(priv_mode_i);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    localparam bit NEXT = (i < NUM_CTR - 1);
    logic hit;
    assign hit = wr_en_i && (idx_i == MY_IDX);

    perf_ctr_slice #(.HAS_NEXT(NEXT)) u_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctl_we_i    (hit & sel_ctl_i),
      .cnt_we_i    (hit & ~sel_ctl_i),
      .wdata_i     (wdata_i),
      .evt_i       (evt_i),
      .priv_mode_i (pm),
      .exl_i       (exl_i),
      .ctl_o       (ctl_rd[i]),
      .cnt_o       (cnt_rd[i]),
      .req_o       (req[i])
    );
  end

  assign irq_o = |req;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if ({1'b0, idx_i} == (IDX_W+1)'(i)) rd_mux = sel_ctl_i ? ctl_rd[i] : cnt_rd[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  assert_oob_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && ({1'b0, idx_i} >= NUM_L)) |=> rd_data_o == '0);
endmodule

// File: tb/perf_ctr_unit_tb.sv
module perf_ctr_unit_tb_top;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] evt_i = '0;
  logic [1:0]  priv_mode_i = 2'd3;
  logic        exl_i = 1'b0;
  logic [1:0]  idx_i = '0;
  logic        sel_ctl_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  perf_ctr_unit #(.NUM_CTR(NC), .IDX_W(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .priv_mode_i(priv_mode_i),
    .exl_i(exl_i), .idx_i(idx_i), .sel_ctl_i(sel_ctl_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit c, input logic [31:0] d);
    @(negedge clk);
    idx_i = idx[1:0]; sel_ctl_i = c; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int idx, input bit c, output logic [31:0] v);
    @(negedge clk);
    idx_i = idx[1:0]; sel_ctl_i = c; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    v = rd_data_o;
  endtask

  task automatic pulse(input logic [63:0] e, input logic [1:0] m, input bit x, input int n);
    @(negedge clk);
    evt_i = e; priv_mode_i = m; exl_i = x;
    repeat (n) @(negedge clk);
    evt_i = '0;
  endtask

  function automatic bit permit(input logic [3:0] mask, input logic [1:0] m, input bit x);
    if (x) return mask[0];
    case (m)
      2'd0: return mask[1];
      2'd1: return mask[2];
      2'd2: return mask[3];
      default: return 1'b0;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    for (int i = 0; i < NC; i++) begin
      rd(i, 1'b1, v); chk("R1 ctl", v, (i < NC-1) ? 32'h8000_0000 : 32'h0);
      rd(i, 1'b0, v); chk("R1 cnt", v, 32'h0);
    end

    // R2 and R3 field layout and chain flag
    for (int i = 0; i < NC; i++) begin
      wr(i, 1'b1, 32'hFFFF_FFFF);
      rd(i, 1'b1, v); chk("R2 R3 ctl all ones", v, ((i < NC-1) ? 32'h8000_0000 : 32'h0) | 32'h7FF);
      wr(i, 1'b1, 32'h0);
      rd(i, 1'b1, v); chk("R3 ctl zero write", v, (i < NC-1) ? 32'h8000_0000 : 32'h0);
    end

    // R4 exhaustive permission sweep on counter 0, event select varies
    for (int mask = 0; mask < 16; mask++) begin
      for (int m = 0; m < 4; m++) begin
        for (int x = 0; x < 2; x++) begin
          automatic int sel = (mask * 8 + m * 2 + x) % 64;
          wr(0, 1'b0, 32'h0);
          wr(0, 1'b1, 32'(mask) | (32'(sel) << 5));
          pulse(64'h1 << sel, m[1:0], x[0], 1);
          rd(0, 1'b0, v);
          chk("R4 permission", v, {31'b0, permit(mask[3:0], m[1:0], x[0])});
        end
      end
    end

    // R5 event selection: other lines ignored, selected line counts
    for (int s = 0; s < 64; s += 7) begin
      wr(1, 1'b0, 32'h0);
      wr(1, 1'b1, 32'h2 | (32'(s) << 5));
      pulse(~(64'h1 << s), 2'd0, 1'b0, 3);
      rd(1, 1'b0, v); chk("R5 unselected", v, 32'h0);
      pulse(64'h1 << s, 2'd0, 1'b0, 4);
      rd(1, 1'b0, v); chk("R5 selected", v, 32'h4);
    end

    // R7 preload period
    for (int n = 1; n <= 6; n++) begin
      wr(0, 1'b1, 32'h0);
      wr(0, 1'b0, 32'h8000_0000 - 32'(n));
      wr(0, 1'b1, 32'h12 | (32'd2 << 5));
      for (int k = 1; k <= n; k++) begin
        pulse(64'h4, 2'd0, 1'b0, 1);
        chk("R7 irq after event", {31'b0, irq_o}, {31'b0, k == n});
      end
      wr(0, 1'b0, 32'h0);
      chk("R6 irq cleared by rewrite", {31'b0, irq_o}, 32'h0);
    end

    // R6 OR of requests and enable gating
    wr(0, 1'b1, 32'h0);
    wr(1, 1'b1, 32'h0);
    wr(0, 1'b0, 32'h8000_0000);
    chk("R6 no enable", {31'b0, irq_o}, 32'h0);
    wr(2, 1'b0, 32'h8000_0001);
    wr(2, 1'b1, 32'h10);
    chk("R6 counter 2 req", {31'b0, irq_o}, 32'h1);
    wr(2, 1'b1, 32'h0);
    chk("R6 ctl off", {31'b0, irq_o}, 32'h0);
    wr(0, 1'b1, 32'h10);
    chk("R6 counter 0 req", {31'b0, irq_o}, 32'h1);
    wr(0, 1'b1, 32'h0);
    wr(2, 1'b0, 32'h0);

    // R8 write beats increment
    wr(1, 1'b0, 32'h0);
    wr(1, 1'b1, 32'h2);
    @(negedge clk);
    evt_i = 64'h1; priv_mode_i = 2'd0; exl_i = 1'b0;
    idx_i = 2'd1; sel_ctl_i = 1'b0; wdata_i = 32'h0000_0100; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; evt_i = '0;
    rd(1, 1'b0, v); chk("R8 write priority", v, 32'h0000_0100);

    // R9 wrap
    wr(1, 1'b0, 32'hFFFF_FFFF);
    pulse(64'h1, 2'd0, 1'b0, 1);
    rd(1, 1'b0, v); chk("R9 wrap", v, 32'h0);
    pulse(64'h1, 2'd0, 1'b0, 2);
    rd(1, 1'b0, v); chk("R9 after wrap", v, 32'h2);

    // R11 zero control stops counting
    wr(1, 1'b1, 32'h0);
    for (int m = 0; m < 4; m++) pulse('1, m[1:0], m[0], 2);
    rd(1, 1'b0, v); chk("R11 stopped", v, 32'h2);

    // R10 out-of-range index
    wr(3, 1'b1, 32'hFFFF_FFFF);
    wr(3, 1'b0, 32'h1234_5678);
    rd(3, 1'b1, v); chk("R10 oob ctl", v, 32'h0);
    rd(3, 1'b0, v); chk("R10 oob cnt", v, 32'h0);
    rd(2, 1'b1, v); chk("R10 neighbour ctl untouched", v, 32'h0);
    rd(0, 1'b0, v); chk("R10 neighbour cnt untouched", v, 32'h8000_0000);

    finish_run();
  end
endmodule